// File: doc/BRIEF.md
# Link Status Evaluator and Drive Adjuster

This block is the decision step of a serial display link training loop. Each time a fresh six-byte link-status snapshot has been read back from the sink, the controller presents it with the number of lanes in use and pulses `in_valid`. On the next cycle the block reports two verdicts. The first is whether clock recovery has finished on every active lane. The second is whether channel equalization and inter-lane alignment have both finished.

In the same cycle the block produces one drive-setting byte that holds a voltage-swing level and a pre-emphasis level. To form it, the block takes the largest of the sink's per-lane adjustment requests, counting the active lanes only. It then limits the swing to the top level and limits pre-emphasis to a ceiling that depends on the chosen swing. Each limit that is hit sets its own flag. The byte is copied to all four lane-setting outputs, so the transmitter and the sink's lane-setting registers can be loaded directly.

Snapshot byte order, from the lowest byte of `link_status` upward: byte 0 holds the status of lanes 0 and 1, byte 1 the status of lanes 2 and 3, byte 2 the alignment byte, byte 3 the sink status (unused), byte 4 the adjust requests of lanes 0 and 1, and byte 5 the adjust requests of lanes 2 and 3.

Top module: `link_drive_eval`

## Requirements
- R1: On a cycle with `in_valid` high, the verdicts and lane settings are registered at the next clock edge and `out_valid` is high for exactly that following cycle. Without a strobe, `out_valid` is low and every other output holds its last value, whatever the inputs do.
- R2: While `rst_n` is low, every output is zero.
- R3: Lane n takes a 4-bit status nibble from status byte n/2: the lower nibble for even lanes and the upper nibble for odd lanes. Within a nibble, bit 0 means clock recovered, bit 1 means equalized and bit 2 means symbol locked.
- R4: `cr_done` is 1 only when bit 0 of the nibble is set for every active lane. Inactive lanes are ignored.
- R5: `eq_done` is 1 only when bit 0 of the alignment byte (byte 2) is set and every active lane has nibble bits 0, 1 and 2 all set. The sink-status byte has no effect.
- R6: Adjust requests are 2-bit levels taken from adjust byte 4 + n/2. For an even lane the swing is in bits [1:0] and the pre-emphasis in bits [3:2]. For an odd lane the swing is in bits [5:4] and the pre-emphasis in bits [7:6].
- R7: The chosen swing and the chosen pre-emphasis are each the maximum of the requests over the active lanes only.
- R8: When the chosen swing reaches level 3, the swing field is 3 and the max-swing flag is set. Otherwise the flag is clear.
- R9: The pre-emphasis ceiling is 2 for swing 0 or 1, 1 for swing 2 and 0 for swing 3. When the requested pre-emphasis is at or above the ceiling, the field takes the ceiling and the max-pre-emphasis flag is set. Otherwise the flag is clear.
- R10: `lane_sel` selects 1 lane (code 0), 2 lanes (code 1) or 4 lanes (codes 2 and 3). All four lane-setting bytes carry the same value for every lane count.
- R11: Setting byte layout: swing in [1:0], max-swing flag in [2], pre-emphasis in [4:3], max-pre-emphasis flag in [5], and bits [7:6] zero. Lane n's byte sits at `lane_setting[8n+7:8n]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe marking a snapshot to evaluate |
| lane_sel | input | 2 | Active lane count code |
| link_status | input | 48 | Six-byte status snapshot, byte 0 lowest |
| out_valid | output | 1 | High for the cycle after a strobe |
| cr_done | output | 1 | Clock recovery complete on all active lanes |
| eq_done | output | 1 | Equalization and alignment complete |
| lane_setting | output | 32 | Four copies of the drive-setting byte |

## Verification
A wrong lane-to-nibble or lane-to-field mapping shows up one cycle after the strobe. Depending on which lane holds the odd value, the result is a wrong verdict, or a swing or pre-emphasis level that fails to track the request. A lane mask that counts inactive lanes shows up as a verdict or level that responds to bytes that should have been ignored. A register that loads without a strobe changes an output during an idle gap. That change is seen at the first sample after the gap starts. The ceiling table and the two flags are visible directly in the setting byte on the cycle after the strobe.

// File: rtl/lse_pkg.sv
package lse_pkg;
  typedef logic [1:0] lvl_t;

  localparam lvl_t SWING_TOP  = 2'd3;
  localparam int   NIB_CR     = 0;
  localparam int   NIB_EQ     = 1;
  localparam int   NIB_LOCK   = 2;
  localparam int   ALIGN_DONE = 0;

  // Ceiling on pre-emphasis for a given swing level
  function automatic lvl_t pre_ceiling(lvl_t swing);
    case (swing)
      2'd0, 2'd1: return 2'd2;
      2'd2:       return 2'd1;
      default:    return 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] lane_nibble(logic [7:0] b, logic odd);
    return odd ? b[7:4] : b[3:0];
  endfunction

  function automatic lvl_t req_swing(logic [7:0] b, logic odd);
    return odd ? b[5:4] : b[1:0];
  endfunction

  function automatic lvl_t req_pre(logic [7:0] b, logic odd);
    return odd ? b[7:6] : b[3:2];
  endfunction

  function automatic logic [7:0] pack_setting(lvl_t sw, logic sw_flag,
                                              lvl_t pe, logic pe_flag);
    return {2'b00, pe_flag, pe, sw_flag, sw};
  endfunction
endpackage

// File: rtl/lse_lane_status.sv
module lse_lane_status
  import lse_pkg::*;
#(
  parameter int LANES = 4,
  localparam int GB   = LANES / 2
) (
  input  logic [8*GB-1:0] status_grp,
  input  logic [7:0]      align_byte,
  input  logic [LANES-1:0] active,
  output logic            cr_all,
  output logic            eq_all
);
  logic [LANES-1:0] lane_cr_ok;
  logic [LANES-1:0] lane_eq_ok;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic [3:0] nib;
    assign nib = lane_nibble(status_grp[8*(n/2) +: 8], 1'(n % 2));
    assign lane_cr_ok[n] = nib[NIB_CR] | ~active[n];
    assign lane_eq_ok[n] = (nib[NIB_CR] & nib[NIB_EQ] & nib[NIB_LOCK]) | ~active[n];
  end

  assign cr_all = &lane_cr_ok;
  assign eq_all = align_byte[ALIGN_DONE] & (&lane_eq_ok);
endmodule

// File: rtl/lse_drive_merge.sv
module lse_drive_merge
  import lse_pkg::*;
#(
  parameter int LANES = 4,
  localparam int GB   = LANES / 2
) (
  input  logic [8*GB-1:0]  adjust_grp,
  input  logic [LANES-1:0] active,
  output lvl_t             swing_max,
  output lvl_t             pre_max,
  output logic [7:0]       setting
);
  lvl_t lane_sw [LANES];
  lvl_t lane_pe [LANES];

  for (genvar n = 0; n < LANES; n++) begin : g_req
    assign lane_sw[n] = active[n] ? req_swing(adjust_grp[8*(n/2) +: 8], 1'(n % 2)) : 2'd0;
    assign lane_pe[n] = active[n] ? req_pre(adjust_grp[8*(n/2) +: 8], 1'(n % 2))   : 2'd0;
  end

  always_comb begin
    swing_max = '0;
    pre_max   = '0;
    for (int n = 0; n < LANES; n++) begin
      if (lane_sw[n] > swing_max) swing_max = lane_sw[n];
      if (lane_pe[n] > pre_max)   pre_max   = lane_pe[n];
    end
  end

  lvl_t sw_final, pe_final, ceil;
  logic sw_hit, pe_hit;

  always_comb begin
    sw_hit   = (swing_max >= SWING_TOP);
    sw_final = sw_hit ? SWING_TOP : swing_max;
    ceil     = pre_ceiling(sw_final);
    pe_hit   = (pre_max >= ceil);
    pe_final = pe_hit ? ceil : pre_max;
  end

  assign setting = pack_setting(sw_final, sw_hit, pe_final, pe_hit);
endmodule

// File: rtl/link_drive_eval.sv
module link_drive_eval
  import lse_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int SEL_W  = 2,
  localparam int GB    = LANES / 2,
  localparam int NBYTE = 2 * GB + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [SEL_W-1:0]   lane_sel,
  input  logic [8*NBYTE-1:0] link_status,
  output logic               out_valid,
  output logic               cr_done,
  output logic               eq_done,
  output logic [8*LANES-1:0] lane_setting
);
  localparam int ALIGN_IX  = GB;
  localparam int SINK_IX   = GB + 1;
  localparam int ADJ_LO    = 8 * (GB + 2);

  logic [LANES-1:0] active;
  int               lane_cnt;

  always_comb begin
    lane_cnt = 1 << lane_sel;
    if (lane_cnt > LANES) lane_cnt = LANES;
    for (int n = 0; n < LANES; n++) active[n] = (n < lane_cnt);
  end

  logic       cr_now, eq_now;
  lvl_t       v_req_max, p_req_max;
  logic [7:0] set_now;

  lse_lane_status #(.LANES(LANES)) u_status (
    .status_grp (link_status[8*GB-1:0]),
    .align_byte (link_status[8*ALIGN_IX +: 8]),
    .active     (active),
    .cr_all     (cr_now),
    .eq_all     (eq_now)
  );

  lse_drive_merge #(.LANES(LANES)) u_merge (
    .adjust_grp (link_status[ADJ_LO +: 8*GB]),
    .active     (active),
    .swing_max  (v_req_max),
    .pre_max    (p_req_max),
    .setting    (set_now)
  );

  logic unused_sink;
  assign unused_sink = ^{link_status[8*SINK_IX +: 8], p_req_max};

  logic [7:0] set_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cr_done   <= 1'b0;
      eq_done   <= 1'b0;
      set_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cr_done <= cr_now;
        eq_done <= eq_now;
        set_q   <= set_now;
      end
    end
  end

  for (genvar n = 0; n < LANES; n++) begin : g_out
    assign lane_setting[8*n +: 8] = set_q;
  end
endmodule

// File: rtl/lde_checker.sv
module lde_checker
  import lse_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               out_valid,
  input logic               cr_done,
  input logic               eq_done,
  input logic [8*LANES-1:0] lane_setting,
  input lvl_t               v_req_max
);
  logic [7:0] s0;
  logic       lanes_same;
  assign s0 = lane_setting[7:0];

  always_comb begin
    lanes_same = 1'b1;
    for (int n = 1; n < LANES; n++)
      if (lane_setting[8*n +: 8] != s0) lanes_same = 1'b0;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(lane_setting) && $stable(cr_done) && $stable(eq_done))); // R1
  AST_EQ_NEEDS_CR: assert property (@(posedge clk) disable iff (!rst_n)
    eq_done |-> cr_done); // R5
  AST_SWING_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (s0[1:0] == $past(v_req_max))); // R7
  AST_SWING_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    s0[2] == (s0[1:0] == SWING_TOP)); // R8
  AST_PRE_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    s0[4:3] <= pre_ceiling(s0[1:0])); // R9
  AST_PRE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    s0[5] == (s0[4:3] == pre_ceiling(s0[1:0]))); // R9
  AST_LANES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    lanes_same); // R10
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    s0[7:6] == 2'b00); // R11
endmodule

bind link_drive_eval lde_checker #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .out_valid    (out_valid),
  .cr_done      (cr_done),
  .eq_done      (eq_done),
  .lane_setting (lane_setting),
  .v_req_max    (v_req_max)
);

// File: tb/tb_link_drive_eval.sv
module tb_link_drive_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  lane_sel = '0;
  logic [47:0] link_status = '0;
  logic        out_valid, cr_done, eq_done;
  logic [31:0] lane_setting;

  always #2.5 clk = ~clk;

  link_drive_eval dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_sel(lane_sel),
    .link_status(link_status), .out_valid(out_valid), .cr_done(cr_done),
    .eq_done(eq_done), .lane_setting(lane_setting)
  );

  int total = 0;
  int errs  = 0;
  bit done  = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {sel[59:58], snapshot[57:10], cr[9], eq[8], setting[7:0]}
  // snapshot bytes high to low: adj23 adj01 sink align st23 st01
  localparam int NV = 9;
  localparam logic [59:0] VEC [NV] = '{
    {2'd2, 48'h00_00_00_01_77_77, 1'b1, 1'b1, 8'h00}, // R3 R4 R5 all lanes done
    {2'd0, 48'h00_F5_00_00_00_01, 1'b1, 1'b0, 8'h09}, // R7 lane1 ignored
    {2'd1, 48'hFF_42_00_01_00_17, 1'b1, 1'b0, 8'h2A}, // R6 R9 odd lane pre
    {2'd2, 48'h30_00_00_01_70_77, 1'b0, 1'b0, 8'h27}, // R8 swing top, ceiling 0
    {2'd2, 48'h00_81_00_00_77_77, 1'b1, 1'b0, 8'h31}, // R5 no align, R9 pre clamp
    {2'd1, 48'h00_12_FF_01_00_77, 1'b1, 1'b1, 8'h02}, // R5 sink byte ignored
    {2'd0, 48'h00_0C_00_01_00_76, 1'b0, 1'b0, 8'h30}, // R4 lane0 no CR, R9
    {2'd3, 48'h12_00_00_01_77_77, 1'b1, 1'b1, 8'h02}, // R10 code 3 is four lanes
    {2'd1, 48'h00_00_00_01_33_33, 1'b1, 1'b0, 8'h00}  // R5 lock bit missing
  };

  task automatic check_vec(int i);
    chk($sformatf("R1 out_valid vec%0d", i), 32'(out_valid), 32'd1);
    chk($sformatf("R4 cr_done vec%0d", i), 32'(cr_done), 32'(VEC[i][9]));
    chk($sformatf("R5 eq_done vec%0d", i), 32'(eq_done), 32'(VEC[i][8]));
    chk($sformatf("R7 R11 setting vec%0d", i), 32'(lane_setting[7:0]), 32'(VEC[i][7:0]));
    for (int n = 1; n < 4; n++)
      chk($sformatf("R10 lane%0d copy vec%0d", n, i),
          32'(lane_setting[8*n +: 8]), 32'(VEC[i][7:0]));
  endtask

  task automatic drive_vec(int i);
    lane_sel    = VEC[i][59:58];
    link_status = VEC[i][57:10];
    in_valid    = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset out_valid", 32'(out_valid), 32'd0);
    chk("R2 reset cr_done", 32'(cr_done), 32'd0);
    chk("R2 reset eq_done", 32'(eq_done), 32'd0);
    chk("R2 reset setting", lane_setting, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive_vec(i);
      @(negedge clk);
      in_valid = 1'b0;
      check_vec(i);
    end

    // Idle hold: after vec3 (setting 27, cr 0), change inputs without a strobe
    @(negedge clk);
    drive_vec(3);
    @(negedge clk);
    in_valid = 1'b0;
    lane_sel = 2'd2;
    link_status = 48'h00_81_00_01_77_77;
    @(negedge clk);
    chk("R1 out_valid low after pulse", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk("R1 hold cr_done", 32'(cr_done), 32'd0);
    chk("R1 hold eq_done", 32'(eq_done), 32'd0);
    chk("R1 hold setting", lane_setting, 32'h27272727);

    // Back-to-back strobes
    @(negedge clk);
    drive_vec(4);
    @(negedge clk);
    check_vec(4);
    drive_vec(5);
    @(negedge clk);
    in_valid = 1'b0;
    check_vec(5);

    // Reset in mid-run clears the outputs
    @(negedge clk);
    drive_vec(2);
    rst_n = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 reset clears out_valid", 32'(out_valid), 32'd0);
    chk("R2 reset clears setting", lane_setting, 32'd0);
    chk("R2 reset clears cr_done", 32'(cr_done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", total - errs, total);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      errs++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - errs, total);
      $finish;
    end
  end
endmodule